// File: doc/BRIEF.md
# Serial Link Receive Character Classifier

This block sits behind the 8b/10b decoder and lane demultiplexer of a packet-based serial link receiver. Each cycle it may accept one 32-bit word of four decoded characters, together with a per-byte control-character flag. It sorts the stream into two outputs. The first is a packet data stream that carries start, end and error markers. The second is a stream of control symbols. Idle words are dropped and never reach either output.

A control-symbol word carries a 19-bit body and a 5-bit CRC. The block recomputes the CRC. A symbol whose CRC fails produces a one-cycle `sym_error` pulse and is discarded. A symbol whose CRC is correct is forwarded. Its type field may also open a packet, close a packet, cancel the packet in progress (stomp) or raise a multicast-event strobe.

Packet data is held back by one word. This lets the final word of a packet carry the end marker, because the block only learns that a word is the last one when the next framing symbol arrives. Packets are limited to a parameterised number of words, and an overrun is reported.

Word layout: byte 3 is `in_data[31:24]`, flagged by `in_kflag[3]`.
- A data word has `in_kflag` equal to 0.
- An idle word has `in_kflag[3]` set and byte 3 equal to `K_IDLE` (default 8'hBC).
- A symbol word has `in_kflag` equal to 4'b1000 and byte 3 equal to `K_CS` (default 8'h7C). In a symbol word, `in_data[23:5]` is the body and `in_data[4:0]` is the CRC.
- The symbol type is body bits [18:16]: 0 opens a packet, 1 ends it, 2 is stomp, 3 is multicast event, and 4 to 7 are other symbols.

Top module: `rxcc_classifier`

## Requirements
- R1: An idle word produces no packet word, no symbol, no pulse and no change to packet state.
- R2: While a packet is open, each data word appears on `pkt_data` unchanged and in order. A word is emitted in the cycle after the next accepted data word or framing symbol arrives. The first word emitted for a packet has `pkt_sop` set.
- R3: An end symbol emits the held word with `pkt_eop` set and `pkt_err` clear, then closes the packet. A packet with no data words emits nothing.
- R4: A symbol word with a correct CRC shows its 19-bit body on `sym_body`, with `sym_valid` high, in the cycle after it is presented. This holds for every type.
- R5: The CRC is x^5+x^4+x^2+1 over the 19 body bits, most significant bit first, with the register preset to all ones. On a mismatch, `sym_error` pulses for one cycle, `sym_valid` stays low, and the symbol has no effect on packets.
- R6: A stomp symbol pulses `stomp` one cycle later. If a word is held, that word is emitted with `pkt_eop` and `pkt_err` set, and the packet closes.
- R7: A multicast-event symbol pulses `mcast` one cycle later and leaves packet state unchanged.
- R8: A packet may hold up to `MAX_WORDS` words; lengths are whole words, so they are always a multiple of 4 bytes. A further data word pulses `size_error`, emits the held word with `pkt_eop` and `pkt_err` set, is itself discarded, and closes the packet.
- R9: A start symbol that arrives while a packet is open emits the held word with `pkt_eop` set and `pkt_err` clear. It then opens a new packet.
- R10: Data words received while no packet is open, words with `in_valid` low, and words with any other flag pattern are discarded without effect.
- R11: After reset, all outputs are low and no packet is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word present |
| in_data | input | 32 | Four decoded characters |
| in_kflag | input | 4 | Control-character flag per byte |
| pkt_valid | output | 1 | Packet word valid |
| pkt_data | output | 32 | Packet word |
| pkt_sop | output | 1 | First word of packet |
| pkt_eop | output | 1 | Last word of packet |
| pkt_err | output | 1 | Packet ended by cancel or overrun |
| sym_valid | output | 1 | Control symbol valid |
| sym_body | output | 19 | Control symbol body |
| sym_error | output | 1 | Symbol CRC mismatch pulse |
| stomp | output | 1 | Stomp symbol pulse |
| mcast | output | 1 | Multicast-event pulse |
| size_error | output | 1 | Packet overrun pulse |

## Verification
The bench builds the block with `MAX_WORDS` set to 8. This lets directed and random packets both reach the exact limit and the overrun within a few cycles. The default of 69 would need packets roughly nine times as long. The symbol delimiter and idle codes stay at their defaults. Random traffic interleaves stomps, corrupted CRCs and start symbols with open packets, which exercises the held-word closing paths in every combination.

// File: rtl/rxcc_pkg.sv
package rxcc_pkg;
    localparam int WORD_W = 32;
    localparam int BODY_W = 19;
    localparam int CRC_W  = 5;
    localparam int TYPE_W = 3;
    localparam logic [CRC_W-1:0] CRC_POLY = 5'b10101;

    typedef enum logic [TYPE_W-1:0] {
        SYM_OPEN  = 3'd0,
        SYM_CLOSE = 3'd1,
        SYM_STOMP = 3'd2,
        SYM_MCAST = 3'd3
    } sym_kind_e;
endpackage

// File: rtl/rxcc_crc5.sv
module rxcc_crc5
    import rxcc_pkg::*;
#(
    parameter int N_BITS = BODY_W
) (
    input  logic [N_BITS-1:0] body,
    output logic [CRC_W-1:0]  crc
);
    logic [CRC_W-1:0] r;
    logic             fb;

    always_comb begin
        r  = '1;
        fb = 1'b0;
        for (int i = N_BITS - 1; i >= 0; i--) begin
            fb = r[CRC_W-1] ^ body[i];
            r  = {r[CRC_W-2:0], 1'b0};
            if (fb) r = r ^ CRC_POLY;
        end
        crc = r;
    end
endmodule

// File: rtl/rxcc_word_decode.sv
module rxcc_word_decode
    import rxcc_pkg::*;
#(
    parameter logic [7:0] K_IDLE = 8'hBC,
    parameter logic [7:0] K_CS   = 8'h7C
) (
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_data,
    input  logic [3:0]        in_kflag,
    output logic              is_data,
    output logic              is_sym,
    output logic [BODY_W-1:0] body,
    output logic [CRC_W-1:0]  crc_rx
);
    logic [7:0] lead;

    always_comb begin
        lead    = in_data[WORD_W-1 -: 8];
        is_data = in_valid && (in_kflag == 4'b0000);
        is_sym  = in_valid && (in_kflag == 4'b1000) && (lead == K_CS);
        body    = in_data[CRC_W +: BODY_W];
        crc_rx  = in_data[CRC_W-1:0];
    end

    // An idle lead character never decodes as data or symbol
    always_comb begin
        if (in_valid && in_kflag[3] && lead == K_IDLE) begin
            assert_idle_not_classified_R1: assert (!is_data && !is_sym);
        end
    end
endmodule

// File: rtl/rxcc_pkt_framer.sv
module rxcc_pkt_framer
    import rxcc_pkg::*;
#(
    parameter int MAX_WORDS = 69
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_data,
    input  logic [WORD_W-1:0] ev_word,
    input  logic              ev_open,
    input  logic              ev_close,
    input  logic              ev_stomp,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_data,
    output logic              out_sop,
    output logic              out_eop,
    output logic              out_err,
    output logic              size_error,
    output logic              stomp_pulse
);
    localparam int CNT_W = $clog2(MAX_WORDS + 1);
    localparam logic [CNT_W-1:0] CNT_LIMIT = CNT_W'(MAX_WORDS);

    typedef struct packed {
        logic              open;
        logic              have;
        logic [WORD_W-1:0] hold;
        logic              hsop;
        logic [CNT_W-1:0]  cnt;
        logic              ov;
        logic [WORD_W-1:0] od;
        logic              osop;
        logic              oeop;
        logic              oerr;
        logic              szerr;
        logic              stomp;
    } frm_t;

    frm_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.ov    = 1'b0;
        st_d.osop  = 1'b0;
        st_d.oeop  = 1'b0;
        st_d.oerr  = 1'b0;
        st_d.szerr = 1'b0;
        st_d.stomp = 1'b0;

        if (ev_data && st_q.open) begin
            if (st_q.cnt == CNT_LIMIT) begin
                st_d.ov    = st_q.have;
                st_d.od    = st_q.hold;
                st_d.osop  = st_q.hsop;
                st_d.oeop  = 1'b1;
                st_d.oerr  = 1'b1;
                st_d.szerr = 1'b1;
                st_d.open  = 1'b0;
                st_d.have  = 1'b0;
            end else begin
                st_d.ov   = st_q.have;
                st_d.od   = st_q.hold;
                st_d.osop = st_q.hsop;
                st_d.hold = ev_word;
                st_d.hsop = (st_q.cnt == '0);
                st_d.have = 1'b1;
                st_d.cnt  = st_q.cnt + CNT_W'(1);
            end
        end else if (ev_open || ev_close || ev_stomp) begin
            st_d.ov    = st_q.have;
            st_d.od    = st_q.hold;
            st_d.osop  = st_q.hsop;
            st_d.oeop  = st_q.have;
            st_d.oerr  = st_q.have && ev_stomp;
            st_d.stomp = ev_stomp;
            st_d.have  = 1'b0;
            st_d.open  = ev_open;
            st_d.cnt   = '0;
        end

        if (!st_d.ov) begin
            st_d.osop = 1'b0;
            st_d.oeop = 1'b0;
            st_d.oerr = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid   = st_q.ov;
    assign out_data    = st_q.od;
    assign out_sop     = st_q.osop;
    assign out_eop     = st_q.oeop;
    assign out_err     = st_q.oerr;
    assign size_error  = st_q.szerr;
    assign stomp_pulse = st_q.stomp;

    assert_overrun_closes_R8: assert property (@(posedge clk) disable iff (!rst_n)
        size_error |-> (out_valid && out_eop && out_err));

    assert_count_bounded_R8: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_LIMIT);

    assert_overrun_then_closed_R8: assert property (@(posedge clk) disable iff (!rst_n)
        size_error |-> !st_q.open);

    assert_sop_needs_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_sop |-> out_valid);

    assert_stomp_never_clean_R6: assert property (@(posedge clk) disable iff (!rst_n)
        stomp_pulse |-> (!out_valid || (out_eop && out_err)));
endmodule

// File: rtl/rxcc_classifier.sv
module rxcc_classifier
    import rxcc_pkg::*;
#(
    parameter int         MAX_WORDS = 69,
    parameter logic [7:0] K_IDLE    = 8'hBC,
    parameter logic [7:0] K_CS      = 8'h7C
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic [31:0] in_data,
    input  logic [3:0]  in_kflag,
    output logic        pkt_valid,
    output logic [31:0] pkt_data,
    output logic        pkt_sop,
    output logic        pkt_eop,
    output logic        pkt_err,
    output logic        sym_valid,
    output logic [18:0] sym_body,
    output logic        sym_error,
    output logic        stomp,
    output logic        mcast,
    output logic        size_error
);
    logic              is_data;
    logic              is_sym;
    logic [BODY_W-1:0] body;
    logic [CRC_W-1:0]  crc_rx;
    logic [CRC_W-1:0]  crc_calc;
    logic              sym_ok;
    logic [TYPE_W-1:0] kind;
    logic              ev_open, ev_close, ev_stomp;

    typedef struct packed {
        logic              sv;
        logic [BODY_W-1:0] sb;
        logic              se;
        logic              mc;
    } symo_t;

    symo_t so_d, so_q;

    rxcc_word_decode #(
        .K_IDLE (K_IDLE),
        .K_CS   (K_CS)
    ) u_decode (
        .in_valid (in_valid),
        .in_data  (in_data),
        .in_kflag (in_kflag),
        .is_data  (is_data),
        .is_sym   (is_sym),
        .body     (body),
        .crc_rx   (crc_rx)
    );

    rxcc_crc5 #(
        .N_BITS (BODY_W)
    ) u_crc (
        .body (body),
        .crc  (crc_calc)
    );

    always_comb begin
        sym_ok   = is_sym && (crc_calc == crc_rx);
        kind     = body[BODY_W-1 -: TYPE_W];
        ev_open  = sym_ok && (kind == SYM_OPEN);
        ev_close = sym_ok && (kind == SYM_CLOSE);
        ev_stomp = sym_ok && (kind == SYM_STOMP);

        so_d.sv = sym_ok;
        so_d.sb = sym_ok ? body : '0;
        so_d.se = is_sym && !sym_ok;
        so_d.mc = sym_ok && (kind == SYM_MCAST);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            so_q <= '0;
        end else begin
            so_q <= so_d;
        end
    end

    rxcc_pkt_framer #(
        .MAX_WORDS (MAX_WORDS)
    ) u_framer (
        .clk         (clk),
        .rst_n       (rst_n),
        .ev_data     (is_data),
        .ev_word     (in_data),
        .ev_open     (ev_open),
        .ev_close    (ev_close),
        .ev_stomp    (ev_stomp),
        .out_valid   (pkt_valid),
        .out_data    (pkt_data),
        .out_sop     (pkt_sop),
        .out_eop     (pkt_eop),
        .out_err     (pkt_err),
        .size_error  (size_error),
        .stomp_pulse (stomp)
    );

    assign sym_valid = so_q.sv;
    assign sym_body  = so_q.sb;
    assign sym_error = so_q.se;
    assign mcast     = so_q.mc;

    assert_bad_symbol_dropped_R5: assert property (@(posedge clk) disable iff (!rst_n)
        sym_error |-> !sym_valid);

    assert_mcast_from_good_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mcast |-> (sym_valid && !stomp));

    assert_idle_silent_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_kflag[3] && in_data[31:24] == K_IDLE)
        |=> (!sym_valid && !pkt_valid && !sym_error));

    assert_symbol_forwarded_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_kflag == 4'b1000 && in_data[31:24] == K_CS
         && crc_calc == in_data[4:0])
        |=> (sym_valid && sym_body == $past(in_data[23:5])));
endmodule

// File: tb/tb_rxcc_classifier.sv
`timescale 1ns/1ps
module tb_rxcc_classifier;
    localparam int         MAXW   = 8;
    localparam logic [7:0] KIDLE  = 8'hBC;
    localparam logic [7:0] KCS    = 8'h7C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_data = '0;
    logic [3:0]  in_kflag = '0;
    logic        pkt_valid, pkt_sop, pkt_eop, pkt_err;
    logic [31:0] pkt_data;
    logic        sym_valid, sym_error, stomp, mcast, size_error;
    logic [18:0] sym_body;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2 clk = ~clk;

    rxcc_classifier #(.MAX_WORDS(MAXW), .K_IDLE(KIDLE), .K_CS(KCS)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_kflag(in_kflag), .pkt_valid(pkt_valid), .pkt_data(pkt_data),
        .pkt_sop(pkt_sop), .pkt_eop(pkt_eop), .pkt_err(pkt_err),
        .sym_valid(sym_valid), .sym_body(sym_body), .sym_error(sym_error),
        .stomp(stomp), .mcast(mcast), .size_error(size_error)
    );

    // reference model state
    bit          m_open, m_have, m_hsop;
    logic [31:0] m_hold;
    int          m_cnt;
    logic [63:0] exp_v;

    // CRC by long division: preset of ones folded into the leading bits
    function automatic logic [4:0] crc_ref(input logic [18:0] b);
        logic [23:0] m;
        m = {b ^ 19'h7C000, 5'b0};
        for (int i = 23; i >= 5; i--)
            if (m[i]) m[i -: 6] = m[i -: 6] ^ 6'b110101;
        return m[4:0];
    endfunction

    function automatic logic [31:0] mk_sym(input logic [2:0] t, input logic [15:0] p, input bit bad);
        logic [18:0] b;
        b = {t, p};
        return {KCS, b, crc_ref(b) ^ (bad ? 5'b00100 : 5'b0)};
    endfunction

    function automatic logic [63:0] pack(input logic pv, input logic [31:0] pd, input logic ps,
                                         input logic pe, input logic pr, input logic sv,
                                         input logic [18:0] sb, input logic se, input logic st,
                                         input logic mc, input logic sz);
        return {4'b0, pv, pv ? pd : 32'h0, pv ? {ps, pe, pr} : 3'b0,
                sv, sv ? sb : 19'h0, se, st, mc, sz};
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] expv);
        n_tests++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    task automatic model(input logic v, input logic [31:0] d, input logic [3:0] k, output string tag);
        logic pv, ps, pe, pr, sv, se, st, mc, sz;
        logic [31:0] pd;
        logic [18:0] sb;
        {pv, ps, pe, pr, sv, se, st, mc, sz} = '0;
        pd = '0; sb = '0;
        tag = "R10";
        if (v && k == 4'b0000) begin
            if (!m_open) tag = "R10";
            else if (m_cnt == MAXW) begin
                tag = "R8";
                pv = m_have; pd = m_hold; ps = m_hsop; pe = 1; pr = 1; sz = 1;
                m_open = 0; m_have = 0;
            end else begin
                tag = "R2";
                pv = m_have; pd = m_hold; ps = m_hsop;
                m_hold = d; m_hsop = (m_cnt == 0); m_have = 1; m_cnt++;
            end
        end else if (v && k[3] && d[31:24] == KIDLE) begin
            tag = "R1";
        end else if (v && k == 4'b1000 && d[31:24] == KCS) begin
            if (crc_ref(d[23:5]) != d[4:0]) begin
                tag = "R5"; se = 1;
            end else begin
                sv = 1; sb = d[23:5]; tag = "R4";
                if (d[23:21] <= 3'd2) begin
                    pv = m_have; pd = m_hold; ps = m_hsop; pe = m_have;
                    pr = m_have && d[23:21] == 3'd2;
                    m_have = 0; m_cnt = 0;
                    m_open = (d[23:21] == 3'd0);
                    tag = (d[23:21] == 3'd2) ? "R6" : (d[23:21] == 3'd1) ? "R3"
                        : (pv ? "R9" : "R2");
                    st = (d[23:21] == 3'd2);
                end else if (d[23:21] == 3'd3) begin
                    mc = 1; tag = "R7";
                end
            end
        end
        exp_v = pack(pv, pd, ps, pe, pr, sv, sb, se, st, mc, sz);
    endtask

    task automatic step(input logic v, input logic [31:0] d, input logic [3:0] k);
        string tag;
        in_valid = v; in_data = d; in_kflag = k;
        @(posedge clk);
        #1;
        model(v, d, k, tag);
        chk(tag, pack(pkt_valid, pkt_data, pkt_sop, pkt_eop, pkt_err, sym_valid,
                      sym_body, sym_error, stomp, mcast, size_error), exp_v);
    endtask

    task automatic dw(input logic [31:0] d); step(1, d, 4'b0000); endtask
    task automatic sy(input logic [2:0] t, input bit bad); step(1, mk_sym(t, 16'h1234 ^ t, bad), 4'b1000); endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2718));
        m_open = 0; m_have = 0; m_hsop = 0; m_hold = '0; m_cnt = 0;
        repeat (3) @(posedge clk);
        #1;
        chk("R11", pack(pkt_valid, pkt_data, pkt_sop, pkt_eop, pkt_err, sym_valid,
                        sym_body, sym_error, stomp, mcast, size_error), 64'h0);
        rst_n = 1'b1;
        // R1 idle, R10 stray data and malformed words
        step(1, {KIDLE, 24'hBCBCBC}, 4'b1111);
        dw(32'hDEAD0001);
        step(1, 32'h11223344, 4'b0100);
        step(0, mk_sym(3'd0, 16'h0, 0), 4'b1000);
        // R2/R3 normal packet
        sy(3'd0, 0); dw(32'hA0000001); dw(32'hA0000002);
        step(1, {KIDLE, 24'h0}, 4'b1000);
        dw(32'hA0000003); sy(3'd1, 0);
        // R3 empty packet
        sy(3'd0, 0); sy(3'd1, 0);
        // R9 start while open
        sy(3'd0, 0); dw(32'hB1); dw(32'hB2); sy(3'd0, 0); dw(32'hB3); sy(3'd1, 0);
        // R6 stomp with held data, then with nothing
        sy(3'd0, 0); dw(32'hC1); dw(32'hC2); sy(3'd2, 0); dw(32'hC3); sy(3'd2, 0);
        // R7 multicast alone and inside a packet
        sy(3'd3, 0); sy(3'd0, 0); dw(32'hD1); sy(3'd3, 0); dw(32'hD2); sy(3'd1, 0);
        // R5 corrupted symbols have no effect
        sy(3'd0, 1); dw(32'hE1); sy(3'd0, 0); dw(32'hE2); sy(3'd1, 1); dw(32'hE3); sy(3'd1, 0);
        // R8 exact limit, then overrun
        sy(3'd0, 0);
        for (int i = 0; i < MAXW; i++) dw(32'hF000_0000 + i);
        sy(3'd1, 0);
        sy(3'd0, 0);
        for (int i = 0; i < MAXW + 2; i++) dw(32'hF100_0000 + i);
        sy(3'd1, 0);
        // R4 other symbol kinds
        sy(3'd5, 0); sy(3'd7, 0);
        // random traffic
        for (int n = 0; n < 4000; n++) begin
            int r;
            r = $urandom % 100;
            if (r < 38)      dw($urandom);
            else if (r < 50) step(1, {KIDLE, 24'($urandom)}, 4'b1000 | 4'($urandom % 8));
            else if (r < 60) sy(3'd0, 0);
            else if (r < 70) sy(3'd1, 0);
            else if (r < 74) sy(3'd2, 0);
            else if (r < 78) sy(3'd3, 0);
            else if (r < 83) step(1, mk_sym(3'($urandom % 8), 16'($urandom), 0), 4'b1000);
            else if (r < 89) step(1, mk_sym(3'($urandom % 8), 16'($urandom), 1), 4'b1000);
            else if (r < 94) step(0, $urandom, 4'($urandom));
            else             step(1, $urandom, 4'b0010);
        end
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule